// File: doc/BRIEF.md
# Road-Start Package Serializer

This block turns stored coincidence events into a stream of per-road packages. Each event held in an upstream show-ahead FIFO carries a 96-bit road-start vector, full second- and third-layer pad rows, an 8-bit bunch number and a cycle bit. The block takes one event at a time and emits one package per set road-start bit, beginning with the highest bit index and going down. Each package carries the road index, a 5-pad window of the second layer, a 6-pad window of the third layer, and the event's bunch number and cycle bit.

The work runs through a three-stage pipeline: priority encode, pad-window select, output register. A programmable cap limits how many packages one event may produce; any flags left over are dropped. A saturating counter records every package that is accepted at the output, and a synchronous clear resets it. The output uses a valid/ready handshake, and the whole pipeline holds while ready is low.

Top module: `road_start_serializer`

## Requirements
- R1: `fifo_pop_o` is asserted only while `fifo_empty_i` is low and no event is in progress, or the current event has no flags left, or the current event has reached its cap. An event whose road-start vector is all zero is consumed and produces no package.
- R2: An event produces exactly one package for each set road-start bit, subject to R7. The packages leave in strictly descending bit-index order, and events are handled in FIFO order.
- R3: `out_code_o` is the 7-bit binary index (0..95) of the road-start bit the package belongs to.
- R4: Bit k (k = 0..4) of `out_l2_o` equals second-layer pad `code + k - 2`. It reads 0 when that position lies outside 0..95.
- R5: Bit k (k = 0..5) of `out_l3_o` equals third-layer pad `code + k - 2`. It reads 0 when that position lies outside 0..95.
- R6: `out_bn_o` and `out_cb_o` carry the bunch number and cycle bit of the event the package came from.
- R7: When `cap_i` is nonzero, an event emits at most `cap_i` packages, namely those of its highest set bits. When `cap_i` is 0 there is no limit.
- R8: While `out_valid_o` is high and `out_ready_i` is low, every output field keeps its value in the next cycle. No package is lost or repeated.
- R9: `pkt_cnt_o` increases by one for each cycle with `out_valid_o` and `out_ready_i` both high, and it saturates at 2^CNT_W-1.
- R10: `cnt_clr_i` zeroes `pkt_cnt_o` at the next clock edge. It takes priority over an increment in the same cycle.
- R11: After reset, `out_valid_o` is low and `pkt_cnt_o` is zero.
- R12: With `out_ready_i` held high, the packages of a single event are accepted in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_empty_i | input | 1 | Upstream FIFO holds no event |
| fifo_pop_o | output | 1 | Consume the event at the FIFO head |
| ev_rsf_i | input | 96 | Road-start vector of head event |
| ev_pad2_i | input | 96 | Second-layer pad row of head event |
| ev_pad3_i | input | 96 | Third-layer pad row of head event |
| ev_bn_i | input | 8 | Bunch number of head event |
| ev_cb_i | input | 1 | Cycle bit of head event |
| cap_i | input | 7 | Packages allowed per event, 0 = unlimited |
| out_valid_o | output | 1 | Package available |
| out_ready_i | input | 1 | Downstream accepts package |
| out_code_o | output | 7 | Road index |
| out_l2_o | output | 5 | Second-layer pad window |
| out_l3_o | output | 6 | Third-layer pad window |
| out_bn_o | output | 8 | Bunch number |
| out_cb_o | output | 1 | Cycle bit |
| cnt_clr_i | input | 1 | Synchronous clear of package counter |
| pkt_cnt_o | output | CNT_W (29) | Saturating count of accepted packages |

## Verification
The serializer is driven with several kinds of event: a single flag in mid-row, flags at both row ends with all pads set, an event with no flags, and a dense event. The mid-row flag confirms the window alignment. The row ends show whether out-of-row pads read as zero. The empty event shows that it is consumed without output. The dense event, with ready held high, confirms the descending order and the one-package-per-cycle rate. A long random stream with random ready stalls tests hold behaviour and order across events, and it drives a narrow counter into saturation. Capped events with caps of 3 and 1 show that only the highest flags survive and that the next event starts cleanly.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int ROW_W  = 96;
  localparam int IDX_W  = $clog2(ROW_W);
  localparam int L2_W   = 5;
  localparam int L3_W   = 6;
  localparam int L2_OFS = 2;
  localparam int L3_OFS = 2;
  localparam int BN_W   = 8;
  localparam int CAP_W  = $clog2(ROW_W + 1);

  typedef struct packed {
    logic [IDX_W-1:0] code;
    logic [L2_W-1:0]  l2;
    logic [L3_W-1:0]  l3;
    logic [BN_W-1:0]  bn;
    logic             cb;
  } pkt_t;
endpackage

// File: rtl/rss_prio_enc.sv
module rss_prio_enc #(
  parameter int W  = 96,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // ascending scan: last hit is the highest set bit
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rss_pad_win.sv
module rss_pad_win #(
  parameter int ROW_W = 96,
  parameter int IW    = $clog2(ROW_W),
  parameter int WIN_W = 5,
  parameter int OFS   = 2
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [IW-1:0]    idx_i,
  output logic [WIN_W-1:0] win_o
);
  localparam int EXT_W = ROW_W + WIN_W + OFS;

  logic [EXT_W-1:0] ext;

  // zero guard bands on both sides so edge roads read 0 outside the row
  generate
    if (OFS > 0) begin : g_lo_pad
      assign ext = {{WIN_W{1'b0}}, row_i, {OFS{1'b0}}};
    end else begin : g_no_pad
      assign ext = {{WIN_W{1'b0}}, row_i};
    end
  endgenerate

  assign win_o = ext[idx_i +: WIN_W];
endmodule

// File: rtl/rss_sat_cnt.sv
module rss_sat_cnt #(
  parameter int W = 29
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (clr_i)                    cnt_o <= '0;
    else if (inc_i && (cnt_o != MAX))  cnt_o <= cnt_o + W'(1);
  end

  // R10
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));

  // R9
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_o == MAX) |=> (cnt_o == MAX));

  // R9
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + W'(1)));
endmodule

// File: rtl/road_start_serializer.sv
module road_start_serializer
  import rss_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  output logic              fifo_pop_o,
  input  logic [ROW_W-1:0]  ev_rsf_i,
  input  logic [ROW_W-1:0]  ev_pad2_i,
  input  logic [ROW_W-1:0]  ev_pad3_i,
  input  logic [BN_W-1:0]   ev_bn_i,
  input  logic              ev_cb_i,
  input  logic [CAP_W-1:0]  cap_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [IDX_W-1:0]  out_code_o,
  output logic [L2_W-1:0]   out_l2_o,
  output logic [L3_W-1:0]   out_l3_o,
  output logic [BN_W-1:0]   out_bn_o,
  output logic              out_cb_o,
  input  logic              cnt_clr_i,
  output logic [CNT_W-1:0]  pkt_cnt_o
);
  // working copy of the current event
  logic              work_v;
  logic [ROW_W-1:0]  w_rsf, w_p2, w_p3;
  logic [BN_W-1:0]   w_bn;
  logic              w_cb;
  logic [CAP_W-1:0]  w_sent;

  logic [IDX_W-1:0]  enc_idx;
  logic              enc_any;
  logic              under_cap, issue, pop;

  // stage 1: encode
  logic              e_v;
  logic [IDX_W-1:0]  e_idx;
  logic [ROW_W-1:0]  e_p2, e_p3;
  logic [BN_W-1:0]   e_bn;
  logic              e_cb;

  // stage 2: select
  logic              s_v;
  pkt_t              s_pkt;
  logic [L2_W-1:0]   win2;
  logic [L3_W-1:0]   win3;

  // stage 3: output register
  logic              o_v;
  pkt_t              o_pkt;

  logic              o_adv, s_adv, e_adv;

  assign o_adv = !o_v || out_ready_i;
  assign s_adv = !s_v || o_adv;
  assign e_adv = !e_v || s_adv;

  rss_prio_enc #(.W(ROW_W), .IW(IDX_W)) u_enc (
    .vec_i (w_rsf),
    .idx_o (enc_idx),
    .any_o (enc_any)
  );

  assign under_cap = (cap_i == '0) || (w_sent < cap_i);
  assign issue     = work_v && enc_any && under_cap && e_adv;
  assign pop       = !fifo_empty_i && (!work_v || !enc_any || !under_cap);
  assign fifo_pop_o = pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_v <= 1'b0;
      w_rsf  <= '0;
      w_p2   <= '0;
      w_p3   <= '0;
      w_bn   <= '0;
      w_cb   <= 1'b0;
      w_sent <= '0;
    end else if (pop) begin
      work_v <= 1'b1;
      w_rsf  <= ev_rsf_i;
      w_p2   <= ev_pad2_i;
      w_p3   <= ev_pad3_i;
      w_bn   <= ev_bn_i;
      w_cb   <= ev_cb_i;
      w_sent <= '0;
    end else if (issue) begin
      w_rsf  <= w_rsf & ~(ROW_W'(1) << enc_idx);
      w_sent <= w_sent + CAP_W'(1);
    end else if (work_v && (!enc_any || !under_cap)) begin
      work_v <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_v   <= 1'b0;
      e_idx <= '0;
      e_p2  <= '0;
      e_p3  <= '0;
      e_bn  <= '0;
      e_cb  <= 1'b0;
    end else if (e_adv) begin
      e_v <= issue;
      if (issue) begin
        e_idx <= enc_idx;
        e_p2  <= w_p2;
        e_p3  <= w_p3;
        e_bn  <= w_bn;
        e_cb  <= w_cb;
      end
    end
  end

  rss_pad_win #(.ROW_W(ROW_W), .IW(IDX_W), .WIN_W(L2_W), .OFS(L2_OFS)) u_win2 (
    .row_i (e_p2),
    .idx_i (e_idx),
    .win_o (win2)
  );

  rss_pad_win #(.ROW_W(ROW_W), .IW(IDX_W), .WIN_W(L3_W), .OFS(L3_OFS)) u_win3 (
    .row_i (e_p3),
    .idx_i (e_idx),
    .win_o (win3)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_v   <= 1'b0;
      s_pkt <= '0;
    end else if (s_adv) begin
      s_v   <= e_v;
      s_pkt <= '{code: e_idx, l2: win2, l3: win3, bn: e_bn, cb: e_cb};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      o_v   <= 1'b0;
      o_pkt <= '0;
    end else if (o_adv) begin
      o_v   <= s_v;
      o_pkt <= s_pkt;
    end
  end

  assign out_valid_o = o_v;
  assign out_code_o  = o_pkt.code;
  assign out_l2_o    = o_pkt.l2;
  assign out_l3_o    = o_pkt.l3;
  assign out_bn_o    = o_pkt.bn;
  assign out_cb_o    = o_pkt.cb;

  rss_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr_i),
    .inc_i  (o_v && out_ready_i),
    .cnt_o  (pkt_cnt_o)
  );

  // R2
  enc_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_any |-> ((w_rsf >> enc_idx) == ROW_W'(1)));

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (o_v && !out_ready_i) |=> (o_v && $stable(o_pkt)));
endmodule

// File: tb/road_start_serializer_test.sv
module road_start_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CNT_W   = 4;
  localparam int CNT_MAX    = (1 << TB_CNT_W) - 1;

  typedef struct packed {
    logic [95:0] rsf;
    logic [95:0] p2;
    logic [95:0] p3;
    logic [7:0]  bn;
    logic        cb;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_empty_i, fifo_pop_o;
  logic [95:0] ev_rsf_i, ev_pad2_i, ev_pad3_i;
  logic [7:0] ev_bn_i;
  logic ev_cb_i;
  logic [6:0] cap_i;
  logic out_valid_o, out_ready_i;
  logic [6:0] out_code_o;
  logic [4:0] out_l2_o;
  logic [5:0] out_l3_o;
  logic [7:0] out_bn_o;
  logic out_cb_o;
  logic cnt_clr_i;
  logic [TB_CNT_W-1:0] pkt_cnt_o;

  road_start_serializer #(.CNT_W(TB_CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fifo_empty_i(fifo_empty_i), .fifo_pop_o(fifo_pop_o),
    .ev_rsf_i(ev_rsf_i), .ev_pad2_i(ev_pad2_i), .ev_pad3_i(ev_pad3_i),
    .ev_bn_i(ev_bn_i), .ev_cb_i(ev_cb_i), .cap_i(cap_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_code_o(out_code_o), .out_l2_o(out_l2_o), .out_l3_o(out_l3_o),
    .out_bn_o(out_bn_o), .out_cb_o(out_cb_o),
    .cnt_clr_i(cnt_clr_i), .pkt_cnt_o(pkt_cnt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  ev_t fq[$];
  logic [26:0] expq[$];
  int cap_v = 0;
  bit rdy_rand = 0, clr_req = 0, did_pop = 0, stall_prev = 0, clr_prev = 0;
  bit b2b_on = 0, done = 0;
  int last_fire = -1, cyc = 0, exp_cnt = 0, wd = 0;
  logic [26:0] held;
  string cur_tag = "R2";

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic bit pad_at(logic [95:0] r, int p);
    return (p >= 0 && p < 96) ? r[p] : 1'b0;
  endfunction

  // reference: expand one event into its expected packages
  function automatic void model_event(ev_t ev, int cap);
    logic [95:0] v = ev.rsf;
    int n = 0;
    while (v != '0 && (cap == 0 || n < cap)) begin
      int top;
      logic [4:0] l2;
      logic [5:0] l3;
      top = 0;
      for (int i = 0; i < 96; i++) if (v[i]) top = i;
      for (int k = 0; k < 5; k++) l2[k] = pad_at(ev.p2, top + k - 2);
      for (int k = 0; k < 6; k++) l3[k] = pad_at(ev.p3, top + k - 2);
      expq.push_back({7'(top), l2, l3, ev.bn, ev.cb});
      v[top] = 1'b0;
      n++;
    end
  endfunction

  task automatic push_ev(ev_t e);
    model_event(e, cap_v);
    fq.push_back(e);
  endtask

  function automatic logic [26:0] out_word();
    return {out_code_o, out_l2_o, out_l3_o, out_bn_o, out_cb_o};
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [26:0] w, e;
      bit fire;
      cyc++;
      if (did_pop && fq.size() > 0) void'(fq.pop_front());
      // R9 counts, R10 after a clear
      check(pkt_cnt_o == TB_CNT_W'(exp_cnt), clr_prev ? "R10" : "R9", pkt_cnt_o, exp_cnt);
      if (stall_prev) check(out_valid_o && out_word() == held, "R8", out_word(), held);
      out_ready_i = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
      cnt_clr_i = clr_req;
      clr_req = 0;
      fifo_empty_i = (fq.size() == 0);
      if (fq.size() > 0) begin
        ev_rsf_i = fq[0].rsf; ev_pad2_i = fq[0].p2; ev_pad3_i = fq[0].p3;
        ev_bn_i = fq[0].bn; ev_cb_i = fq[0].cb;
      end else begin
        ev_rsf_i = '0; ev_pad2_i = '0; ev_pad3_i = '0; ev_bn_i = '0; ev_cb_i = 1'b0;
      end
      cap_i = 7'(cap_v);
      #1;
      did_pop = fifo_pop_o;
      if (fifo_pop_o) check(fq.size() > 0, "R1", 64'(fifo_pop_o), 64'(fq.size() > 0));
      fire = out_valid_o && out_ready_i;
      if (fire) begin
        w = out_word();
        if (expq.size() == 0) begin
          check(0, "R2", w, 0);
        end else begin
          e = expq.pop_front();
          check(w[26:20] == e[26:20], "R3", w[26:20], e[26:20]);
          check(w[19:15] == e[19:15], "R4", w[19:15], e[19:15]);
          check(w[14:9]  == e[14:9],  "R5", w[14:9],  e[14:9]);
          check(w[8:0]   == e[8:0],   "R6", w[8:0],   e[8:0]);
          check(w == e, cur_tag, w, e);
        end
        if (b2b_on && last_fire >= 0) check(cyc == last_fire + 1, "R12", cyc, last_fire + 1);
        last_fire = cyc;
      end
      clr_prev = cnt_clr_i;
      if (cnt_clr_i) exp_cnt = 0;
      else if (fire && exp_cnt < CNT_MAX) exp_cnt++;
      stall_prev = out_valid_o && !out_ready_i;
      held = out_word();
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R2 act=timeout exp=finish");
      finish_run();
    end
  end

  task automatic drain(input string tag);
    int k;
    for (k = 0; k < 4000; k++) begin
      if (fq.size() == 0 && expq.size() == 0 && !out_valid_o) break;
      @(posedge clk); #2;
    end
    check(k < 4000, tag, expq.size(), 0);
    repeat (6) begin @(posedge clk); #2; end
  endtask

  function automatic ev_t mk(logic [95:0] rsf, logic [95:0] p2, logic [95:0] p3, logic [7:0] bn, logic cb);
    ev_t e;
    e.rsf = rsf; e.p2 = p2; e.p3 = p3; e.bn = bn; e.cb = cb;
    return e;
  endfunction

  function automatic logic [95:0] rnd96();
    return {$urandom, $urandom, $urandom};
  endfunction

  initial begin
    fifo_empty_i = 1'b1; out_ready_i = 1'b1; cnt_clr_i = 1'b0; cap_i = '0;
    ev_rsf_i = '0; ev_pad2_i = '0; ev_pad3_i = '0; ev_bn_i = '0; ev_cb_i = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R11 during reset
    check(!out_valid_o, "R11", out_valid_o, 0);
    check(pkt_cnt_o == '0, "R11", pkt_cnt_o, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check(!out_valid_o, "R11", out_valid_o, 0);
    check(!fifo_pop_o, "R1", fifo_pop_o, 0);

    // single mid-row road
    cur_tag = "R3";
    push_ev(mk(96'(1) << 50, 96'h1F << 46, 96'h2D << 47, 8'hA5, 1'b1));
    drain("R3");

    // row edges with all pads set
    cur_tag = "R4";
    push_ev(mk((96'(1) << 95) | 96'h3, '1, '1, 8'h3C, 1'b0));
    drain("R5");

    // empty event then one road
    cur_tag = "R1";
    push_ev(mk('0, '1, '1, 8'h11, 1'b1));
    push_ev(mk(96'(1) << 7, rnd96(), rnd96(), 8'h22, 1'b0));
    drain("R1");

    // dense event, ready high: back-to-back
    cur_tag = "R12";
    b2b_on = 1; last_fire = -1;
    push_ev(mk(96'h8421_0000_0000_0000_0000_1248 | (96'(1) << 60), rnd96(), rnd96(), 8'h5A, 1'b1));
    drain("R12");
    b2b_on = 0;

    // cap
    cur_tag = "R7";
    cap_v = 3;
    push_ev(mk(96'h0003_0000_00F0_0000_0001, rnd96(), rnd96(), 8'h77, 1'b0));
    push_ev(mk(96'h1, rnd96(), rnd96(), 8'h78, 1'b1));
    drain("R7");
    cap_v = 1;
    push_ev(mk(rnd96(), rnd96(), rnd96(), 8'h79, 1'b0));
    push_ev(mk(rnd96(), rnd96(), rnd96(), 8'h7A, 1'b1));
    drain("R7");
    cap_v = 0;

    // counter clear then random stream with stalls
    clr_req = 1;
    @(posedge clk); #2;
    cur_tag = "R8";
    rdy_rand = 1;
    for (int n = 0; n < 25; n++) begin
      logic [95:0] r;
      r = '0;
      for (int j = 0; j < int'($urandom % 6); j++) r[$urandom % 96] = 1'b1;
      push_ev(mk(r, rnd96(), rnd96(), 8'($urandom), 1'($urandom)));
      if (n == 12) clr_req = 1;
      repeat (int'($urandom % 5)) begin @(posedge clk); #2; end
    end
    drain("R8");
    rdy_rand = 0;
    // R10 explicit
    clr_req = 1;
    repeat (3) begin @(posedge clk); #2; end
    check(pkt_cnt_o == '0, "R10", pkt_cnt_o, 0);
    finish_run();
  end
endmodule